// File: doc/BRIEF.md
# DMA Control Port Write Decoder

This block sits behind the single byte-wide control port of a two-port DMA controller. Each byte that arrives while no parameter sequence is open is a base byte. Fixed bit patterns sort it into one of six setup groups or into the command group. A setup byte is stored in its own register. Some of its bits also say which parameter bytes will follow it. Those parameter ids are loaded into a short queue in a fixed order. The bytes written after that are steered, one by one, into the parameter registers that the queue names.

The queue can grow while it is being consumed. When the interrupt-control parameter is accepted, its own bits may append a pulse-control byte and then an interrupt-vector byte. Command bytes raise a one-cycle strobe on a one-hot vector, and a few of them also update the DMA-enable and interrupt-enable flags. The transfer engine, the readback path and the interrupt logic sit outside this block and only read the registers and strobes it provides.

Top module: `dmadec_top`

## Requirements
- R1: A synchronous active-high reset clears every register, the DMA-enable and interrupt-enable flags, the strobe vector and the pending queue, and leaves `busy` low.
- R2: A base byte with (byte & 0x87) == 0x04 is stored in `a_cfg`, and its bit 6 queues one byte for `a_timing`. A base byte with (byte & 0x87) == 0x00 is stored in `b_cfg`, and its bit 6 queues one byte for `b_timing`.
- R3: Any other base byte with bit 7 clear is stored in `xfer_ctl`. Its bits 3, 4, 5 and 6 queue, in this order, the low and high bytes of `a_addr` and the low and high bytes of `blk_len`. Only the bytes whose bits are set are queued.
- R4: A base byte with (byte & 0x83) == 0x80 is stored in `cmp_ctl`. Its bit 6 is copied to `dma_en` and its bit 5 to `irq_en`. Its bit 3 queues `cmp_mask` and its bit 4 queues `cmp_match`, in that order.
- R5: A base byte with (byte & 0x83) == 0x81 is stored in `b_ctl`. Its bits 2, 3 and 4 queue, in this order, the low byte of `b_addr`, the high byte of `b_addr` and `irq_ctl`.
- R6: When a byte is written into `irq_ctl`, its bit 3 appends a byte for `pulse_ctl` and its bit 4 then appends a byte for `irq_vec`, both to the end of the current sequence.
- R7: A base byte with (byte & 0xC7) == 0x82 is stored in `pin_ctl`. Any other base byte with (byte & 0x83) == 0x82 changes no register, flag, strobe or `busy`.
- R8: A base byte with (byte & 0x83) == 0x83 is a command. It raises exactly one bit of `cmd_pulse` for the single cycle after the write, with these bit indices: 0x83→0, 0x87→1, 0x8B→2, 0xA3→3, 0xA7→4, 0xAB→5, 0xAF→6, 0xB3→7, 0xB7→8, 0xBB→9, 0xBF→10, 0xC3→11, 0xC7→12, 0xCB→13, 0xD3→14. Any other code in this group raises no bit. `cmd_pulse` is zero in every cycle that does not follow a command write.
- R9: Command 0x87 sets `dma_en` and command 0x83 clears it. Command 0xAB sets `irq_en`. Commands 0xAF and 0xA3 clear `irq_en`. Command 0xC3 clears both flags.
- R10: Command 0xBB queues exactly one following byte, which is written into `rd_mask`.
- R11: While `busy` is high, every written byte is a parameter for the register at the head of the queue, whatever its bit pattern. `busy` falls after the last queued byte has been written.
- R12: A base byte that queues no parameter bytes leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe on the control port |
| wr_data | input | 8 | Written byte |
| busy | output | 1 | A parameter sequence is open |
| dma_en | output | 1 | DMA enabled flag |
| irq_en | output | 1 | Interrupts enabled flag |
| cmd_pulse | output | 15 | One-hot, one-cycle command strobes |
| xfer_ctl | output | 8 | Transfer setup base byte |
| a_addr | output | 16 | Port A start address |
| blk_len | output | 16 | Block length |
| a_cfg | output | 8 | Port A setup base byte |
| a_timing | output | 8 | Port A timing byte |
| b_cfg | output | 8 | Port B setup base byte |
| b_timing | output | 8 | Port B timing byte |
| cmp_ctl | output | 8 | Compare setup base byte |
| cmp_mask | output | 8 | Compare mask |
| cmp_match | output | 8 | Compare match value |
| b_ctl | output | 8 | Port B address and interrupt setup base byte |
| b_addr | output | 16 | Port B start address |
| irq_ctl | output | 8 | Interrupt control byte |
| pulse_ctl | output | 8 | Pulse control byte |
| irq_vec | output | 8 | Interrupt vector byte |
| pin_ctl | output | 8 | Ready and wait setup byte |
| rd_mask | output | 8 | Readback mask |

## Verification
The hardest case to reach is a sequence that grows after it has started. Here the queue holds only three entries when the interrupt-control byte is written, and that byte then adds two more, so `busy` must stay high past the original end. The stimulus opens the port B setup with all three qualifiers set and writes an interrupt-control byte with both append bits set. It checks that the last two bytes land in pulse control and then in the vector. A second, shorter run appends only the pulse byte, and the check confirms that the vector keeps its earlier value. Parameter bytes that look like commands are also written mid-sequence, which shows that an open sequence masks the decode.

// File: rtl/dmadec_pkg.sv
package dmadec_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam int NCMD   = 15;
  localparam int NPAR   = 14;
  localparam int PID_W  = $clog2(NPAR);

  // Parameter ids; within one group the numeric order is the queue order.
  typedef enum logic [PID_W-1:0] {
    PR_A_LO, PR_A_HI, PR_LEN_LO, PR_LEN_HI,
    PR_A_TIM, PR_B_TIM,
    PR_MASK, PR_MATCH,
    PR_B_LO, PR_B_HI, PR_ICTRL, PR_PULSE, PR_VEC,
    PR_RDMASK
  } par_e;

  typedef enum logic [2:0] {
    GR_XFER, GR_PA, GR_PB, GR_CMP, GR_PORTB, GR_PIN, GR_CMD, GR_NONE
  } grp_e;

  // Strobe bit indices, ascending by command code.
  localparam int CI_DIS_DMA  = 0;
  localparam int CI_EN_DMA   = 1;
  localparam int CI_REINIT   = 2;
  localparam int CI_RST_DINT = 3;
  localparam int CI_RD_SEQ   = 4;
  localparam int CI_EN_INT   = 5;
  localparam int CI_DIS_INT  = 6;
  localparam int CI_FORCE    = 7;
  localparam int CI_EN_RETI  = 8;
  localparam int CI_RDMASK   = 9;
  localparam int CI_RD_STAT  = 10;
  localparam int CI_RESET    = 11;
  localparam int CI_RST_ATIM = 12;
  localparam int CI_RST_BTIM = 13;
  localparam int CI_CONT     = 14;
endpackage

// File: rtl/dmadec_classify.sv
module dmadec_classify
  import dmadec_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  output grp_e              grp,
  output logic [NPAR-1:0]   fol,
  output logic [NCMD-1:0]   cmd_hot
);
  always_comb begin
    grp     = GR_NONE;
    fol     = '0;
    cmd_hot = '0;
    if ((byte_in & 8'h87) == 8'h00) begin
      grp = GR_PB;
      fol[int'(PR_B_TIM)] = byte_in[6];
    end else if ((byte_in & 8'h87) == 8'h04) begin
      grp = GR_PA;
      fol[int'(PR_A_TIM)] = byte_in[6];
    end else if (!byte_in[7]) begin
      grp = GR_XFER;
      fol[int'(PR_A_LO)]   = byte_in[3];
      fol[int'(PR_A_HI)]   = byte_in[4];
      fol[int'(PR_LEN_LO)] = byte_in[5];
      fol[int'(PR_LEN_HI)] = byte_in[6];
    end else if ((byte_in & 8'h83) == 8'h80) begin
      grp = GR_CMP;
      fol[int'(PR_MASK)]  = byte_in[3];
      fol[int'(PR_MATCH)] = byte_in[4];
    end else if ((byte_in & 8'h83) == 8'h81) begin
      grp = GR_PORTB;
      fol[int'(PR_B_LO)]  = byte_in[2];
      fol[int'(PR_B_HI)]  = byte_in[3];
      fol[int'(PR_ICTRL)] = byte_in[4];
    end else if ((byte_in & 8'hC7) == 8'h82) begin
      grp = GR_PIN;
    end else if ((byte_in & 8'h83) == 8'h83) begin
      grp = GR_CMD;
      case (byte_in)
        8'h83: cmd_hot[CI_DIS_DMA]  = 1'b1;
        8'h87: cmd_hot[CI_EN_DMA]   = 1'b1;
        8'h8B: cmd_hot[CI_REINIT]   = 1'b1;
        8'hA3: cmd_hot[CI_RST_DINT] = 1'b1;
        8'hA7: cmd_hot[CI_RD_SEQ]   = 1'b1;
        8'hAB: cmd_hot[CI_EN_INT]   = 1'b1;
        8'hAF: cmd_hot[CI_DIS_INT]  = 1'b1;
        8'hB3: cmd_hot[CI_FORCE]    = 1'b1;
        8'hB7: cmd_hot[CI_EN_RETI]  = 1'b1;
        8'hBB: begin
          cmd_hot[CI_RDMASK] = 1'b1;
          fol[int'(PR_RDMASK)] = 1'b1;
        end
        8'hBF: cmd_hot[CI_RD_STAT]  = 1'b1;
        8'hC3: cmd_hot[CI_RESET]    = 1'b1;
        8'hC7: cmd_hot[CI_RST_ATIM] = 1'b1;
        8'hCB: cmd_hot[CI_RST_BTIM] = 1'b1;
        8'hD3: cmd_hot[CI_CONT]     = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dmadec_seq.sv
module dmadec_seq
  import dmadec_pkg::*;
#(
  parameter int QDEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [NPAR-1:0]   fol,
  output logic              busy,
  output logic              base_we,
  output logic              par_we,
  output par_e              cur_par
);
  localparam int QW = $clog2(QDEPTH);
  localparam int PW = QW + 1;

  par_e           q [QDEPTH];
  logic [PW-1:0]  cnt_q, ptr_q;
  par_e           ld_list [QDEPTH];
  logic [PW-1:0]  ld_cnt;
  par_e           ap0, ap1;
  logic [PW-1:0]  ap_cnt;
  logic [QW-1:0]  wi0, wi1;

  assign base_we = wr_en && !busy;
  assign par_we  = wr_en && busy;

  // Compact the qualifier mask into an ordered list of ids.
  always_comb begin
    logic [PW-1:0] rank;
    rank = '0;
    for (int k = 0; k < QDEPTH; k++) ld_list[k] = PR_A_LO;
    for (int i = 0; i < NPAR; i++) begin
      if (fol[i]) begin
        for (int k = 0; k < QDEPTH; k++)
          if (rank == PW'(k)) ld_list[k] = par_e'(PID_W'(i));
        rank = rank + PW'(1);
      end
    end
    ld_cnt = rank;
  end

  // Head of queue.
  always_comb begin
    cur_par = PR_A_LO;
    for (int k = 0; k < QDEPTH; k++)
      if (ptr_q[QW-1:0] == QW'(k)) cur_par = q[k];
  end

  // Entries appended by the interrupt-control byte.
  always_comb begin
    ap0    = PR_PULSE;
    ap1    = PR_VEC;
    ap_cnt = '0;
    if (cur_par == PR_ICTRL) begin
      if (wr_data[3] && wr_data[4]) begin
        ap_cnt = PW'(2);
      end else if (wr_data[3]) begin
        ap_cnt = PW'(1);
      end else if (wr_data[4]) begin
        ap0    = PR_VEC;
        ap_cnt = PW'(1);
      end
    end
  end

  assign wi0 = cnt_q[QW-1:0];
  assign wi1 = wi0 + QW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      ptr_q <= '0;
      for (int k = 0; k < QDEPTH; k++) q[k] <= PR_A_LO;
    end else if (base_we) begin
      cnt_q <= ld_cnt;
      ptr_q <= '0;
      busy  <= (ld_cnt != '0);
      for (int k = 0; k < QDEPTH; k++)
        if (PW'(k) < ld_cnt) q[k] <= ld_list[k];
    end else if (par_we) begin
      cnt_q <= cnt_q + ap_cnt;
      ptr_q <= ptr_q + PW'(1);
      busy  <= (ptr_q + PW'(1)) < (cnt_q + ap_cnt);
      for (int k = 0; k < QDEPTH; k++) begin
        if (ap_cnt != '0 && wi0 == QW'(k)) q[k] <= ap0;
        if (ap_cnt == PW'(2) && wi1 == QW'(k)) q[k] <= ap1;
      end
    end
  end
endmodule

// File: rtl/dmadec_regs.sv
module dmadec_regs
  import dmadec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  grp_e              grp,
  input  logic [NCMD-1:0]   cmd_hot,
  input  logic              par_we,
  input  par_e              cur_par,
  input  logic [BYTE_W-1:0] d,
  output logic              dma_en,
  output logic              irq_en,
  output logic [NCMD-1:0]   cmd_pulse,
  output logic [BYTE_W-1:0] xfer_ctl,
  output logic [ADDR_W-1:0] a_addr,
  output logic [ADDR_W-1:0] blk_len,
  output logic [BYTE_W-1:0] a_cfg,
  output logic [BYTE_W-1:0] a_timing,
  output logic [BYTE_W-1:0] b_cfg,
  output logic [BYTE_W-1:0] b_timing,
  output logic [BYTE_W-1:0] cmp_ctl,
  output logic [BYTE_W-1:0] cmp_mask,
  output logic [BYTE_W-1:0] cmp_match,
  output logic [BYTE_W-1:0] b_ctl,
  output logic [ADDR_W-1:0] b_addr,
  output logic [BYTE_W-1:0] irq_ctl,
  output logic [BYTE_W-1:0] pulse_ctl,
  output logic [BYTE_W-1:0] irq_vec,
  output logic [BYTE_W-1:0] pin_ctl,
  output logic [BYTE_W-1:0] rd_mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dma_en <= 1'b0;  irq_en <= 1'b0;  cmd_pulse <= '0;
      xfer_ctl <= '0;  a_addr <= '0;    blk_len <= '0;
      a_cfg <= '0;     a_timing <= '0;  b_cfg <= '0;   b_timing <= '0;
      cmp_ctl <= '0;   cmp_mask <= '0;  cmp_match <= '0;
      b_ctl <= '0;     b_addr <= '0;    irq_ctl <= '0;
      pulse_ctl <= '0; irq_vec <= '0;   pin_ctl <= '0; rd_mask <= '0;
    end else begin
      cmd_pulse <= '0;
      if (base_we) begin
        case (grp)
          GR_XFER:  xfer_ctl <= d;
          GR_PA:    a_cfg    <= d;
          GR_PB:    b_cfg    <= d;
          GR_CMP: begin
            cmp_ctl <= d;
            dma_en  <= d[6];
            irq_en  <= d[5];
          end
          GR_PORTB: b_ctl    <= d;
          GR_PIN:   pin_ctl  <= d;
          GR_CMD: begin
            cmd_pulse <= cmd_hot;
            if (cmd_hot[CI_EN_DMA])  dma_en <= 1'b1;
            if (cmd_hot[CI_DIS_DMA]) dma_en <= 1'b0;
            if (cmd_hot[CI_EN_INT])  irq_en <= 1'b1;
            if (cmd_hot[CI_DIS_INT] || cmd_hot[CI_RST_DINT]) irq_en <= 1'b0;
            if (cmd_hot[CI_RESET]) begin
              dma_en <= 1'b0;
              irq_en <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (par_we) begin
        case (cur_par)
          PR_A_LO:   a_addr[BYTE_W-1:0]       <= d;
          PR_A_HI:   a_addr[ADDR_W-1:BYTE_W]  <= d;
          PR_LEN_LO: blk_len[BYTE_W-1:0]      <= d;
          PR_LEN_HI: blk_len[ADDR_W-1:BYTE_W] <= d;
          PR_A_TIM:  a_timing  <= d;
          PR_B_TIM:  b_timing  <= d;
          PR_MASK:   cmp_mask  <= d;
          PR_MATCH:  cmp_match <= d;
          PR_B_LO:   b_addr[BYTE_W-1:0]       <= d;
          PR_B_HI:   b_addr[ADDR_W-1:BYTE_W]  <= d;
          PR_ICTRL:  irq_ctl   <= d;
          PR_PULSE:  pulse_ctl <= d;
          PR_VEC:    irq_vec   <= d;
          PR_RDMASK: rd_mask   <= d;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmadec_top.sv
module dmadec_top
  import dmadec_pkg::*;
#(
  parameter int QDEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              busy,
  output logic              dma_en,
  output logic              irq_en,
  output logic [NCMD-1:0]   cmd_pulse,
  output logic [BYTE_W-1:0] xfer_ctl,
  output logic [ADDR_W-1:0] a_addr,
  output logic [ADDR_W-1:0] blk_len,
  output logic [BYTE_W-1:0] a_cfg,
  output logic [BYTE_W-1:0] a_timing,
  output logic [BYTE_W-1:0] b_cfg,
  output logic [BYTE_W-1:0] b_timing,
  output logic [BYTE_W-1:0] cmp_ctl,
  output logic [BYTE_W-1:0] cmp_mask,
  output logic [BYTE_W-1:0] cmp_match,
  output logic [BYTE_W-1:0] b_ctl,
  output logic [ADDR_W-1:0] b_addr,
  output logic [BYTE_W-1:0] irq_ctl,
  output logic [BYTE_W-1:0] pulse_ctl,
  output logic [BYTE_W-1:0] irq_vec,
  output logic [BYTE_W-1:0] pin_ctl,
  output logic [BYTE_W-1:0] rd_mask
);
  grp_e            grp;
  logic [NPAR-1:0] fol;
  logic [NCMD-1:0] cmd_hot;
  logic            base_we, par_we;
  par_e            cur_par;

  dmadec_classify u_cls (
    .byte_in (wr_data),
    .grp     (grp),
    .fol     (fol),
    .cmd_hot (cmd_hot)
  );

  dmadec_seq #(.QDEPTH(QDEPTH)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .fol     (fol),
    .busy    (busy),
    .base_we (base_we),
    .par_we  (par_we),
    .cur_par (cur_par)
  );

  dmadec_regs u_regs (
    .clk (clk), .rst (rst),
    .base_we (base_we), .grp (grp), .cmd_hot (cmd_hot),
    .par_we (par_we), .cur_par (cur_par), .d (wr_data),
    .dma_en (dma_en), .irq_en (irq_en), .cmd_pulse (cmd_pulse),
    .xfer_ctl (xfer_ctl), .a_addr (a_addr), .blk_len (blk_len),
    .a_cfg (a_cfg), .a_timing (a_timing),
    .b_cfg (b_cfg), .b_timing (b_timing),
    .cmp_ctl (cmp_ctl), .cmp_mask (cmp_mask), .cmp_match (cmp_match),
    .b_ctl (b_ctl), .b_addr (b_addr), .irq_ctl (irq_ctl),
    .pulse_ctl (pulse_ctl), .irq_vec (irq_vec),
    .pin_ctl (pin_ctl), .rd_mask (rd_mask)
  );
endmodule

// File: rtl/dmadec_chk.sv
module dmadec_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [7:0]  wr_data,
  input logic        busy,
  input logic        dma_en,
  input logic [14:0] cmd_pulse,
  input logic [7:0]  pin_ctl
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_pulse)); // R8
  AST_STROBE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (cmd_pulse == '0)); // R8
  AST_OPEN_SEQ_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> (cmd_pulse == '0)); // R11
  AST_DMA_ON: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && wr_data == 8'h87) |=> dma_en); // R9
  AST_DMA_OFF: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && wr_data == 8'h83) |=> !dma_en); // R9
  AST_RDMASK_OPENS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && wr_data == 8'hBB) |=> busy); // R10
  AST_PIN_STORE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && (wr_data & 8'hC7) == 8'h82) |=> (pin_ctl == $past(wr_data))); // R7
endmodule

bind dmadec_top dmadec_chk u_chk (
  .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
  .busy (busy), .dma_en (dma_en), .cmd_pulse (cmd_pulse), .pin_ctl (pin_ctl)
);

// File: tb/dmadec_top_test.sv
module dmadec_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        busy, dma_en, irq_en;
  logic [14:0] cmd_pulse;
  logic [7:0]  xfer_ctl, a_cfg, a_timing, b_cfg, b_timing, cmp_ctl, cmp_mask, cmp_match;
  logic [7:0]  b_ctl, irq_ctl, pulse_ctl, irq_vec, pin_ctl, rd_mask;
  logic [15:0] a_addr, blk_len, b_addr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic seen = 1'b0;
  logic [14:0] exp_q[$];
  string       req_q[$];

  always #4 clk = ~clk;

  dmadec_top uut (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
    .busy (busy), .dma_en (dma_en), .irq_en (irq_en), .cmd_pulse (cmd_pulse),
    .xfer_ctl (xfer_ctl), .a_addr (a_addr), .blk_len (blk_len),
    .a_cfg (a_cfg), .a_timing (a_timing), .b_cfg (b_cfg), .b_timing (b_timing),
    .cmp_ctl (cmp_ctl), .cmp_mask (cmp_mask), .cmp_match (cmp_match),
    .b_ctl (b_ctl), .b_addr (b_addr), .irq_ctl (irq_ctl),
    .pulse_ctl (pulse_ctl), .irq_vec (irq_vec), .pin_ctl (pin_ctl), .rd_mask (rd_mask)
  );

  function automatic logic [14:0] hot(int idx);
    return 15'(1) << idx;
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Driver: one write, with the expected strobe pushed to the scoreboard.
  task automatic wr(logic [7:0] d, logic [14:0] exp_pulse, string req);
    @(negedge clk);
    exp_q.push_back(exp_pulse);
    req_q.push_back(req);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  always @(posedge clk) seen <= wr_en && !rst;

  // Monitor: compares strobes against the scoreboard after every cycle.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (seen) begin
        if (exp_q.size() == 0) chk("R8 scoreboard empty", 16'(cmd_pulse), 16'hFFFF);
        else chk({req_q.pop_front(), " strobe"}, 16'(cmd_pulse), 16'(exp_q.pop_front()));
      end else begin
        chk("R8 idle strobe", 16'(cmd_pulse), 16'h0000);
      end
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog got=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 busy", 16'(busy), 0);
    chk("R1 dma_en", 16'(dma_en), 0);
    chk("R1 irq_en", 16'(irq_en), 0);
    chk("R1 a_addr", a_addr, 0);
    chk("R1 rd_mask", 16'(rd_mask), 0);

    // R3 full transfer setup
    wr(8'h79, 0, "R3"); chk("R3 busy", 16'(busy), 1);
    wr(8'h34, 0, "R3"); wr(8'h12, 0, "R3");
    wr(8'hFF, 0, "R3"); wr(8'h00, 0, "R3");
    chk("R3 xfer_ctl", 16'(xfer_ctl), 16'h79);
    chk("R3 a_addr", a_addr, 16'h1234);
    chk("R3 blk_len", blk_len, 16'h00FF);
    chk("R11 busy end", 16'(busy), 0);
    // R3 sparse: only A low and length low
    wr(8'h29, 0, "R3"); wr(8'h56, 0, "R3"); wr(8'h77, 0, "R3");
    chk("R3 sparse a_addr", a_addr, 16'h1256);
    chk("R3 sparse blk_len", blk_len, 16'h0077);
    chk("R3 sparse busy", 16'(busy), 0);

    // R2 port A with timing; timing byte looks like a reset command (R11)
    wr(8'h44, 0, "R2"); chk("R2 a_cfg", 16'(a_cfg), 16'h44);
    wr(8'hC3, 0, "R11");
    chk("R11 a_timing", 16'(a_timing), 16'hC3);
    chk("R11 busy", 16'(busy), 0);
    // R2 port B
    wr(8'h40, 0, "R2"); wr(8'h0E, 0, "R2");
    chk("R2 b_cfg", 16'(b_cfg), 16'h40);
    chk("R2 b_timing", 16'(b_timing), 16'h0E);
    wr(8'h10, 0, "R12");
    chk("R12 b_cfg", 16'(b_cfg), 16'h10);
    chk("R12 busy", 16'(busy), 0);

    // R4 compare setup
    wr(8'hF8, 0, "R4");
    chk("R4 dma_en", 16'(dma_en), 1);
    chk("R4 irq_en", 16'(irq_en), 1);
    wr(8'h0F, 0, "R4"); wr(8'hA5, 0, "R4");
    chk("R4 cmp_ctl", 16'(cmp_ctl), 16'hF8);
    chk("R4 cmp_mask", 16'(cmp_mask), 16'h0F);
    chk("R4 cmp_match", 16'(cmp_match), 16'hA5);

    // R5 + R6 growing sequence
    wr(8'h9D, 0, "R5"); wr(8'hCD, 0, "R5"); wr(8'hAB, 0, "R5");
    wr(8'h18, 0, "R6");
    chk("R6 busy after ictrl", 16'(busy), 1);
    wr(8'h55, 0, "R6"); wr(8'h66, 0, "R6");
    chk("R5 b_ctl", 16'(b_ctl), 16'h9D);
    chk("R5 b_addr", b_addr, 16'hABCD);
    chk("R5 irq_ctl", 16'(irq_ctl), 16'h18);
    chk("R6 pulse_ctl", 16'(pulse_ctl), 16'h55);
    chk("R6 irq_vec", 16'(irq_vec), 16'h66);
    chk("R6 busy", 16'(busy), 0);
    // R6 pulse only
    wr(8'h91, 0, "R6"); wr(8'h08, 0, "R6"); wr(8'h77, 0, "R6");
    chk("R6 pulse only", 16'(pulse_ctl), 16'h77);
    chk("R6 vec kept", 16'(irq_vec), 16'h66);
    chk("R6 busy short", 16'(busy), 0);

    // R7 pin setup and ignored pattern
    wr(8'h8A, 0, "R7"); chk("R7 pin_ctl", 16'(pin_ctl), 16'h8A);
    wr(8'hCA, 0, "R7");
    chk("R7 ignored pin_ctl", 16'(pin_ctl), 16'h8A);
    chk("R7 ignored busy", 16'(busy), 0);
    chk("R7 ignored dma_en", 16'(dma_en), 1);

    // R8 / R9 commands
    wr(8'hAF, hot(6), "R9"); chk("R9 irq off", 16'(irq_en), 0);
    wr(8'hAB, hot(5), "R9"); chk("R9 irq on", 16'(irq_en), 1);
    wr(8'h83, hot(0), "R9"); chk("R9 dma off", 16'(dma_en), 0);
    wr(8'h87, hot(1), "R9"); chk("R9 dma on", 16'(dma_en), 1);
    wr(8'hA3, hot(3), "R9"); chk("R9 irq off2", 16'(irq_en), 0);
    wr(8'hAB, hot(5), "R9");
    wr(8'hD3, hot(14), "R8");
    wr(8'hC7, hot(12), "R8");
    wr(8'hB7, hot(8), "R8");
    wr(8'h8F, 0, "R8");
    chk("R8 unknown busy", 16'(busy), 0);
    wr(8'hC3, hot(11), "R9");
    chk("R9 reset dma", 16'(dma_en), 0);
    chk("R9 reset irq", 16'(irq_en), 0);

    // R10 read mask
    wr(8'hBB, hot(9), "R10"); chk("R10 busy", 16'(busy), 1);
    wr(8'h7F, 0, "R10");
    chk("R10 rd_mask", 16'(rd_mask), 16'h7F);
    chk("R10 busy end", 16'(busy), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule